// File: doc/BRIEF.md
# Low-Power Stop and Wake Controller

This controller sits next to a small processor core and handles its low-power stop. When the core requests a stop, the controller records the interrupt priority mask that the status register holds at that moment. It then drops the core clock enable and keeps the core asleep until a qualifying wake event arrives. Two kinds of event wake it: a hardware reset, or an interrupt whose level is strictly above the recorded mask. Level 7 is non-maskable and always wakes it. All other activity is ignored while the core is asleep.

Software has to program the mask before it issues the stop, because only the value present on the request cycle counts. Each stop passes through the same four states: running, a one-cycle save, sleep, and a one-cycle wake. During the wake cycle the controller reports why the core woke.

Top module: `lps_ctrl`

## Requirements
- R1: A stop request sampled while running loads `ipl_mask_i` into `saved_mask_o` on that edge. The next cycle is a single save cycle, with `core_clk_en_o` still 1 and `sleeping_o` 0.
- R2: The cycle after the save cycle enters sleep. `sleeping_o` is 1 and `core_clk_en_o` is 0 for every sleep cycle, until a wake event ends sleep.
- R3: `saved_mask_o` holds its value while asleep. Changes on `ipl_mask_i` during sleep have no effect on the wake decision.
- R4: While asleep, an interrupt level greater than `saved_mask_o` causes a move to the wake cycle on the next edge, with `wake_cause_o` = 2'b10.
- R5: While asleep, a level below 7 and at or below `saved_mask_o` does not wake the core. Level 0 means no interrupt.
- R6: Level 7 always wakes the core, even when the saved mask is 7. The reported cause is 2'b10.
- R7: `hw_reset_i` asserted while asleep wakes the core with `wake_cause_o` = 2'b01. It takes priority over a simultaneous interrupt.
- R8: The wake cycle lasts exactly one cycle, with `core_clk_en_o` 1 and `sleeping_o` 0. The core then returns to running, and `wake_cause_o` is 2'b00 in every state other than the wake cycle.
- R9: A stop request during save, sleep or wake is ignored. It neither starts a new stop nor reloads `saved_mask_o`.
- R10: An active-low `rst_ni` returns the controller at once to running. In that state `core_clk_en_o` is 1, `sleeping_o` is 0, `saved_mask_o` is 0 and `wake_cause_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller |
| stop_req_i | input | 1 | Low-power stop request from the core |
| ipl_mask_i | input | 3 | Current interrupt priority mask from the status register |
| hw_reset_i | input | 1 | Hardware reset wake event |
| irq_level_i | input | 3 | Highest pending interrupt level, 0 = none |
| core_clk_en_o | output | 1 | Clock enable for the gated part of the core |
| sleeping_o | output | 1 | High while the core is asleep |
| saved_mask_o | output | 3 | Mask recorded at the last accepted stop request |
| wake_cause_o | output | 2 | 01 reset, 10 interrupt, valid only in the wake cycle |

## Verification
The assertions check several rules on every cycle. Sleep always means the clock enable is low. The recorded mask never changes during sleep. A level at or below the mask, other than 7, never ends sleep. Reset or a qualifying level ends sleep on the next edge with the correct cause code. A cause code lasts only one cycle and only follows sleep. The bench scenarios cover what those properties cannot see: the mask is loaded on the request cycle and not from the live input later, the save cycle lasts exactly one cycle, requests arriving during save and sleep are ignored, and an asynchronous reset taken in the middle of sleep.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SAVE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } lps_state_e;

  localparam int CAUSE_W = 2;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 2'b00;
  localparam logic [CAUSE_W-1:0] CAUSE_RST  = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ  = 2'b10;
endpackage

// File: rtl/lps_wake_eval.sv
module lps_wake_eval
  import lps_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0]   irq_level_i,
  input  logic [LVL_W-1:0]   saved_mask_i,
  input  logic               hw_reset_i,
  output logic               wake_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic nmi, above;

  // top level is non-maskable
  assign nmi   = &irq_level_i;
  assign above = irq_level_i > saved_mask_i;

  always_comb begin
    if (hw_reset_i) begin
      wake_o  = 1'b1;
      cause_o = CAUSE_RST;
    end else if (nmi || above) begin
      wake_o  = 1'b1;
      cause_o = CAUSE_IRQ;
    end else begin
      wake_o  = 1'b0;
      cause_o = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/lps_mask_hold.sv
module lps_mask_hold #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic [LVL_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (capture_i) mask_o <= mask_i;
  end
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_req_i,
  input  logic               wake_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               capture_o,
  output lps_state_e         state_o,
  output logic [CAUSE_W-1:0] cause_o
);
  lps_state_e state_d;
  logic [CAUSE_W-1:0] cause_q;

  assign capture_o = (state_o == ST_RUN) && stop_req_i;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_RUN:   if (stop_req_i) state_d = ST_SAVE;
      ST_SAVE:  state_d = ST_SLEEP;
      ST_SLEEP: if (wake_i) state_d = ST_WAKE;
      ST_WAKE:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_RUN;
      cause_q <= CAUSE_NONE;
    end else begin
      state_o <= state_d;
      if (state_o == ST_SLEEP && wake_i) cause_q <= cause_i;
    end
  end

  assign cause_o = (state_o == ST_WAKE) ? cause_q : CAUSE_NONE;
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_req_i,
  input  logic [LVL_W-1:0]   ipl_mask_i,
  input  logic               hw_reset_i,
  input  logic [LVL_W-1:0]   irq_level_i,
  output logic               core_clk_en_o,
  output logic               sleeping_o,
  output logic [LVL_W-1:0]   saved_mask_o,
  output logic [CAUSE_W-1:0] wake_cause_o
);
  logic               capture, wake;
  logic [CAUSE_W-1:0] cause;
  lps_state_e         state;

  lps_wake_eval #(.LVL_W(LVL_W)) u_eval (
    .irq_level_i (irq_level_i),
    .saved_mask_i(saved_mask_o),
    .hw_reset_i  (hw_reset_i),
    .wake_o      (wake),
    .cause_o     (cause)
  );

  lps_mask_hold #(.LVL_W(LVL_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .mask_i   (ipl_mask_i),
    .mask_o   (saved_mask_o)
  );

  lps_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_req_i(stop_req_i),
    .wake_i    (wake),
    .cause_i   (cause),
    .capture_o (capture),
    .state_o   (state),
    .cause_o   (wake_cause_o)
  );

  assign sleeping_o    = (state == ST_SLEEP);
  assign core_clk_en_o = (state != ST_SLEEP);
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hw_reset_i,
  input logic [LVL_W-1:0] irq_level_i,
  input logic             core_clk_en_o,
  input logic             sleeping_o,
  input logic [LVL_W-1:0] saved_mask_o,
  input logic [1:0]       wake_cause_o
);
  localparam logic [LVL_W-1:0] NMI = '1;

  assert_gate_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleeping_o |-> !core_clk_en_o);

  assert_mask_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleeping_o |=> $stable(saved_mask_o));

  assert_no_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && !hw_reset_i && irq_level_i != NMI && irq_level_i <= saved_mask_o)
      |=> sleeping_o);

  assert_irq_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && !hw_reset_i && (irq_level_i > saved_mask_o || irq_level_i == NMI))
      |=> (wake_cause_o == 2'b10 && core_clk_en_o));

  assert_rst_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && hw_reset_i) |=> (wake_cause_o == 2'b01));

  assert_cause_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_cause_o != 2'b00) |=> (wake_cause_o == 2'b00 && !sleeping_o));

  assert_cause_after_sleep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_cause_o != 2'b00) |-> $past(sleeping_o));
endmodule

bind lps_ctrl lps_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hw_reset_i   (hw_reset_i),
  .irq_level_i  (irq_level_i),
  .core_clk_en_o(core_clk_en_o),
  .sleeping_o   (sleeping_o),
  .saved_mask_o (saved_mask_o),
  .wake_cause_o (wake_cause_o)
);

// File: tb/lps_ctrl_test.sv
module lps_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stop_req_i = 1'b0;
  logic [2:0] ipl_mask_i = 3'd0;
  logic       hw_reset_i = 1'b0;
  logic [2:0] irq_level_i = 3'd0;
  logic       core_clk_en_o, sleeping_o;
  logic [2:0] saved_mask_o;
  logic [1:0] wake_cause_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lps_ctrl uut (.*);

  // {mask, level, expect_wake}
  localparam logic [6:0] VEC [12] = '{
    {3'd3, 3'd4, 1'b1}, {3'd3, 3'd3, 1'b0}, {3'd3, 3'd2, 1'b0},
    {3'd0, 3'd1, 1'b1}, {3'd0, 3'd0, 1'b0}, {3'd6, 3'd7, 1'b1},
    {3'd7, 3'd7, 1'b1}, {3'd7, 3'd6, 1'b0}, {3'd5, 3'd6, 1'b1},
    {3'd2, 3'd7, 1'b1}, {3'd4, 3'd5, 1'b1}, {3'd6, 3'd6, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // status packed as {clk_en, sleeping, cause}
  function automatic int st();
    return {core_clk_en_o, sleeping_o, wake_cause_o};
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic enter_sleep(input logic [2:0] m);
    ipl_mask_i = m;
    stop_req_i = 1'b1;
    tick();
    stop_req_i = 1'b0;
    chk("R1 save cycle", st(), 4'b1000);
    chk("R1 mask captured", saved_mask_o, m);
    tick();
    chk("R2 sleeping", st(), 4'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset state", {st(), saved_mask_o}, 7'b1000_000);
    rst_ni = 1'b1;
    tick();

    foreach (VEC[i]) begin
      enter_sleep(VEC[i][6:4]);
      ipl_mask_i = 3'd0;  // live mask change must not matter (R3)
      irq_level_i = VEC[i][3:1];
      tick();
      if (VEC[i][0]) begin
        chk(VEC[i][3:1] == 3'd7 ? "R6 nmi wake" : "R4 irq wake", st(), 4'b1010);
        irq_level_i = 3'd0;
      end else begin
        chk("R5 no wake / R3 live mask ignored", st(), 4'b0100);
        chk("R3 mask held", saved_mask_o, VEC[i][6:4]);
        irq_level_i = 3'd0;
        hw_reset_i = 1'b1;
        tick();
        hw_reset_i = 1'b0;
        chk("R7 reset wake", st(), 4'b1001);
      end
      tick();
      chk("R8 back to run", st(), 4'b1000);
    end

    // R7: reset beats a qualifying interrupt
    enter_sleep(3'd1);
    hw_reset_i = 1'b1;
    irq_level_i = 3'd7;
    tick();
    hw_reset_i = 1'b0;
    irq_level_i = 3'd0;
    chk("R7 reset priority", st(), 4'b1001);
    tick();
    chk("R8 cause cleared", st(), 4'b1000);

    // R9: request held into save cycle with new mask is ignored
    ipl_mask_i = 3'd2;
    stop_req_i = 1'b1;
    tick();
    ipl_mask_i = 3'd5;
    tick();
    chk("R9 save-cycle request ignored", saved_mask_o, 2);
    chk("R9 sleeping", st(), 4'b0100);
    // R9: request while asleep ignored
    ipl_mask_i = 3'd6;
    tick();
    stop_req_i = 1'b0;
    chk("R9 sleep request ignored", {st(), saved_mask_o}, {4'b0100, 3'd2});
    irq_level_i = 3'd3;
    tick();
    irq_level_i = 3'd0;
    chk("R9 wake uses old mask", st(), 4'b1010);
    tick();

    // R10: async reset mid-sleep
    enter_sleep(3'd4);
    #3 rst_ni = 1'b0;
    #2 chk("R10 async reset", {st(), saved_mask_o}, 7'b1000_000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    chk("R10 stays running", st(), 4'b1000);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule